// File: doc/BRIEF.md
# Retrace-Synchronized Palette Fade Engine

This block walks a colour lookup table of red, green and blue components toward a chosen target colour, one step per pass. Black is the usual target. It keeps its own working copy of every component byte in a small internal RAM, which the host preloads through a write port while the engine is idle. After `start`, the engine runs an adjustment pass over the whole table. Each component moves toward its target component by the step size and never passes it. The engine then streams the updated table into an index/data palette port of the kind a DAC uses. The table goes out in chunks, and each chunk is sent inside a separate vertical retrace.

A chunk may begin only at the onset of a retrace. The engine first has to observe the synchronized retrace input low, which is active display, and then watch it go high. A retrace that is already in progress when the engine becomes ready is therefore never used. The engine stops on its own after a pass that moves no component, and it reports this with `done`. An `abort` request takes effect only at a chunk boundary.

The states are IDLE, ADJUST, WAIT_LOW, WAIT_HIGH, INDEX and STREAM. The transitions are:
- IDLE→ADJUST when `start` is seen.
- ADJUST→WAIT_LOW at the end of a pass that moved something.
- ADJUST→IDLE at the end of a pass that moved nothing (done), or on abort.
- WAIT_LOW→WAIT_HIGH when the retrace is low.
- WAIT_HIGH→INDEX when the retrace is high.
- INDEX→STREAM always.
- STREAM→WAIT_LOW at the end of a chunk that is not the last one.
- STREAM→ADJUST at the end of the last chunk.
- STREAM→IDLE at a chunk end once abort has been requested.
- WAIT_LOW/WAIT_HIGH→IDLE on abort.

Top module: `pal_fade_engine`

## Requirements
- R1: After reset, `busy`, `done`, `pal_idx_we` and `pal_dat_we` are all low, and no palette write is made while `busy` is low.
- R2: Each chunk opens with one `pal_idx_we` cycle carrying the index of the first colour in that chunk. The first chunk of every upload carries index 0. The data bytes that follow go out one per cycle in ascending colour order, with the components of each colour in the order red, green, blue.
- R3: A chunk holds exactly CHUNK colours (3*CHUNK data bytes). One upload is NCOLORS/CHUNK chunks, and every chunk has its own index write.
- R4: A chunk starts only after the synchronized retrace input has been seen low and then high. At most one chunk is sent per retrace, and a retrace already running when the engine becomes ready is skipped. If a retrace lasts longer than 3*CHUNK+SYNC_STAGES+2 cycles, every palette write of that chunk falls inside it.
- R5: A component above its target decreases by min(step, distance) per pass. It saturates at the target, so with a target of 0 it never wraps below zero.
- R6: A component below its target increases by min(step, distance) per pass and stops at the target without overshoot.
- R7: The step size and the target colour are captured at `start`. After upload k (counting from 1), each component equals its start value moved toward its target by min(k*step, distance).
- R8: When a complete pass moves no component, the engine returns to idle without uploading and raises `done`. The number of uploads is therefore the largest ceil(distance/step) over all components, and 0 when step is 0 or the table already equals the target.
- R9: Once `abort` is asserted, the chunk being streamed finishes in full. The engine then goes idle with `done` low and makes no further palette writes.
- R10: `done` stays high until the next accepted `start`. In the cycle after that start, `busy` is high and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fade; accepted only while idle |
| abort | input | 1 | Stop at the next chunk boundary |
| step | input | CW | Amount moved per pass, captured at start |
| tgt_red | input | CW | Target red component |
| tgt_grn | input | CW | Target green component |
| tgt_blu | input | CW | Target blue component |
| load_we | input | 1 | Write one byte of the working table while idle |
| load_addr | input | AW | Byte address: colour*3 + component (0 red, 1 green, 2 blue) |
| load_data | input | CW | Byte to load |
| vretrace | input | 1 | Vertical retrace, high while retrace is active |
| pal_idx_we | output | 1 | Palette index write strobe |
| pal_idx | output | IDXW | Colour index written to the palette port |
| pal_dat_we | output | 1 | Palette data write strobe (index auto-advances downstream) |
| pal_dat | output | CW | Component byte written to the palette port |
| busy | output | 1 | Engine active |
| done | output | 1 | Fade converged; held until next start |

## Verification
Two events can fall in the same cycle. One is an abort request arriving while the last byte of a chunk is on the port, at the moment the chunk-end decision is taken. The other is a start issued in the middle of a retrace, which collides with the retrace handshake. The bench raises `abort` exactly during the final data byte of the first chunk. It then expects a full chunk of bytes, an idle engine with `done` low, and no index or data writes afterwards. Every vector is started while the retrace input is high. Each index write is accepted only if a retrace rising edge has occurred since the start or since the previous index write.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [2:0] {
        PF_IDLE,
        PF_ADJUST,
        PF_WAIT_LOW,
        PF_WAIT_HIGH,
        PF_INDEX,
        PF_STREAM
    } pf_state_e;

    localparam int PF_COMPONENTS = 3;

endpackage

// File: rtl/pf_stepper.sv
module pf_stepper #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] tgt,
    input  logic [W-1:0] step,
    output logic [W-1:0] nxt,
    output logic         moved
);
    logic [W-1:0] gap;
    logic [W-1:0] amount;

    always_comb begin
        gap    = (cur < tgt) ? (tgt - cur) : (cur - tgt);
        amount = (step < gap) ? step : gap;
        nxt    = (cur < tgt) ? (cur + amount) : (cur - amount);
        moved  = (nxt != cur);
    end
endmodule

// File: rtl/pf_palram.sv
module pf_palram #(
    parameter int DEPTH = 768,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/pf_sync.sv
module pf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic s1;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s1 <= 1'b0;
                else        s1 <= d;
            end
            assign q = s1;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/pal_fade_engine.sv
module pal_fade_engine
    import pf_pkg::*;
#(
    parameter int  NCOLORS     = 256,
    parameter int  CHUNK       = 128,
    parameter int  CW          = 8,
    parameter int  SYNC_STAGES = 2,
    localparam int NBYTES      = NCOLORS * PF_COMPONENTS,
    localparam int AW          = $clog2(NBYTES),
    localparam int IDXW        = $clog2(NCOLORS),
    localparam int CHUNK_BYTES = CHUNK * PF_COMPONENTS,
    localparam int BCW         = $clog2(CHUNK_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            abort,
    input  logic [CW-1:0]   step,
    input  logic [CW-1:0]   tgt_red,
    input  logic [CW-1:0]   tgt_grn,
    input  logic [CW-1:0]   tgt_blu,
    input  logic            load_we,
    input  logic [AW-1:0]   load_addr,
    input  logic [CW-1:0]   load_data,
    input  logic            vretrace,
    output logic            pal_idx_we,
    output logic [IDXW-1:0] pal_idx,
    output logic            pal_dat_we,
    output logic [CW-1:0]   pal_dat,
    output logic            busy,
    output logic            done
);
    pf_state_e state_q, state_d;

    logic [AW-1:0]   addr_q;
    logic [1:0]      comp_q;
    logic [IDXW-1:0] col_q;
    logic [BCW-1:0]  bcnt_q;
    logic            changed_q;
    logic            abort_q;
    logic            done_q;
    logic [CW-1:0]   step_q;
    logic [2:0][CW-1:0] tgt_q;

    logic            vr_s;
    logic            ram_we;
    logic [AW-1:0]   ram_addr;
    logic [CW-1:0]   ram_wdata;
    logic [CW-1:0]   ram_rdata;
    logic [CW-1:0]   comp_tgt;
    logic [CW-1:0]   adj_value;
    logic            moved;

    logic abort_hit, last_byte, chunk_end, changed_any;

    pf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (vretrace),
        .q     (vr_s)
    );

    pf_palram #(.DEPTH(NBYTES), .W(CW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    pf_stepper #(.W(CW)) u_step (
        .cur   (ram_rdata),
        .tgt   (comp_tgt),
        .step  (step_q),
        .nxt   (adj_value),
        .moved (moved)
    );

    always_comb begin
        abort_hit   = abort_q | abort;
        last_byte   = (addr_q == AW'(NBYTES - 1));
        chunk_end   = (bcnt_q == BCW'(CHUNK_BYTES - 1));
        changed_any = changed_q | moved;
        comp_tgt    = tgt_q[comp_q];
        ram_we      = (state_q == PF_IDLE) ? load_we : (state_q == PF_ADJUST);
        ram_addr    = (state_q == PF_IDLE) ? load_addr : addr_q;
        ram_wdata   = (state_q == PF_IDLE) ? load_data : adj_value;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PF_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_IDLE: begin
                if (start) state_d = PF_ADJUST;
            end
            PF_ADJUST: begin
                if (last_byte) begin
                    if (abort_hit)        state_d = PF_IDLE;
                    else if (changed_any) state_d = PF_WAIT_LOW;
                    else                  state_d = PF_IDLE;
                end
            end
            PF_WAIT_LOW: begin
                if (abort_hit)  state_d = PF_IDLE;
                else if (!vr_s) state_d = PF_WAIT_HIGH;
            end
            PF_WAIT_HIGH: begin
                if (abort_hit) state_d = PF_IDLE;
                else if (vr_s) state_d = PF_INDEX;
            end
            PF_INDEX: begin
                state_d = PF_STREAM;
            end
            PF_STREAM: begin
                if (chunk_end) begin
                    if (abort_hit)      state_d = PF_IDLE;
                    else if (last_byte) state_d = PF_ADJUST;
                    else                state_d = PF_WAIT_LOW;
                end
            end
            default: state_d = PF_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy       = (state_q != PF_IDLE);
        pal_idx_we = (state_q == PF_INDEX);
        pal_idx    = col_q;
        pal_dat_we = (state_q == PF_STREAM);
        pal_dat    = ram_rdata;
        done       = done_q;
    end

    // walking datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            comp_q    <= '0;
            col_q     <= '0;
            bcnt_q    <= '0;
            changed_q <= 1'b0;
            abort_q   <= 1'b0;
            done_q    <= 1'b0;
            step_q    <= '0;
            tgt_q     <= '0;
        end else begin
            if (state_q != PF_IDLE && abort) abort_q <= 1'b1;
            unique case (state_q)
                PF_IDLE: begin
                    if (start) begin
                        addr_q    <= '0;
                        comp_q    <= '0;
                        col_q     <= '0;
                        changed_q <= 1'b0;
                        abort_q   <= 1'b0;
                        done_q    <= 1'b0;
                        step_q    <= step;
                        tgt_q     <= {tgt_blu, tgt_grn, tgt_red};
                    end
                end
                PF_ADJUST: begin
                    if (last_byte) begin
                        addr_q    <= '0;
                        comp_q    <= '0;
                        col_q     <= '0;
                        changed_q <= 1'b0;
                        if (!abort_hit && !changed_any) done_q <= 1'b1;
                    end else begin
                        addr_q    <= addr_q + AW'(1);
                        comp_q    <= (comp_q == 2'd2) ? 2'd0 : comp_q + 2'd1;
                        changed_q <= changed_any;
                    end
                end
                PF_INDEX: begin
                    bcnt_q <= '0;
                end
                PF_STREAM: begin
                    bcnt_q <= bcnt_q + BCW'(1);
                    if (last_byte) begin
                        addr_q <= '0;
                        comp_q <= '0;
                        col_q  <= '0;
                    end else begin
                        addr_q <= addr_q + AW'(1);
                        if (comp_q == 2'd2) begin
                            comp_q <= 2'd0;
                            col_q  <= col_q + IDXW'(1);
                        end else begin
                            comp_q <= comp_q + 2'd1;
                        end
                    end
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/pf_fade_checker.sv
module pf_fade_checker #(
    parameter int NCOLORS = 256,
    parameter int CHUNK   = 128,
    localparam int IDXW   = $clog2(NCOLORS)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            pal_idx_we,
    input logic [IDXW-1:0] pal_idx,
    input logic            pal_dat_we,
    input logic            vr_s
);
    logic [15:0] since_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          since_idx <= '0;
        else if (pal_idx_we) since_idx <= '0;
        else if (pal_dat_we) since_idx <= since_idx + 16'd1;
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(pal_idx_we || pal_dat_we));

    assert_chunk_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pal_idx_we |-> ((int'(pal_idx) % CHUNK) == 0));

    assert_chunk_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pal_dat_we |-> (int'(since_idx) < CHUNK * 3));

    assert_retrace_seen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pal_idx_we |-> $past(vr_s));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));
endmodule

bind pal_fade_engine pf_fade_checker #(.NCOLORS(NCOLORS), .CHUNK(CHUNK)) u_fade_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .pal_idx_we (pal_idx_we),
    .pal_idx    (pal_idx),
    .pal_dat_we (pal_dat_we),
    .vr_s       (vr_s)
);

// File: tb/test_pal_fade_engine.sv
`timescale 1ns/1ps
module test_pal_fade_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 8;
    localparam int CH  = 4;
    localparam int NB  = NC * 3;
    localparam int CB  = CH * 3;
    localparam int AW  = $clog2(NB);
    localparam int IW  = $clog2(NC);
    localparam int RH  = 40;
    localparam int RL  = 30;
    localparam int NVEC = 6;

    // {step, tgt_r, tgt_g, tgt_b, base, mult}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'd1, 8'd0,   8'd0,   8'd0,   8'd20,  8'd3},
        {8'd2, 8'd0,   8'd0,   8'd0,   8'd5,   8'd1},
        {8'd3, 8'd50,  8'd10,  8'd30,  8'd40,  8'd1},
        {8'd5, 8'd255, 8'd255, 8'd255, 8'd240, 8'd1},
        {8'd0, 8'd9,   8'd9,   8'd9,   8'd7,   8'd1},
        {8'd4, 8'd0,   8'd0,   8'd0,   8'd0,   8'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [7:0]    step = '0;
    logic [7:0]    tgt_red = '0, tgt_grn = '0, tgt_blu = '0;
    logic          load_we = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [7:0]    load_data = '0;
    logic          vretrace = 1'b0;
    logic          pal_idx_we, pal_dat_we, busy, done;
    logic [IW-1:0] pal_idx;
    logic [7:0]    pal_dat;

    int checks = 0;
    int fails  = 0;

    logic [7:0] orig [NB];
    logic [7:0] vtgt [3];
    int vstep;
    int rise_cnt = 0;
    int last_rise = 0;
    int up_cnt = 0;
    int mon_ptr = 0;
    int mon_cb = 0;
    int idx_total = 0;
    int dat_total = 0;

    pal_fade_engine #(.NCOLORS(NC), .CHUNK(CH), .CW(8), .SYNC_STAGES(2)) i_pal_fade_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .step(step),
        .tgt_red(tgt_red), .tgt_grn(tgt_grn), .tgt_blu(tgt_blu),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .vretrace(vretrace), .pal_idx_we(pal_idx_we), .pal_idx(pal_idx),
        .pal_dat_we(pal_dat_we), .pal_dat(pal_dat), .busy(busy), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model(input int o, input int t, input int s, input int k);
        int d, mv;
        d  = (t > o) ? t - o : o - t;
        mv = s * k;
        if (mv > d) mv = d;
        return (t > o) ? o + mv : o - mv;
    endfunction

    // retrace generator
    initial begin
        forever begin
            repeat (RL) @(negedge clk);
            vretrace = 1'b1;
            rise_cnt++;
            repeat (RH) @(negedge clk);
            vretrace = 1'b0;
        end
    end

    // port monitor
    always begin
        @(negedge clk);
        #1;
        if (rst_n && pal_idx_we) begin
            idx_total++;
            chk(rise_cnt != last_rise, "R4", "fresh retrace before chunk", rise_cnt, last_rise + 1);
            chk(vretrace == 1'b1, "R4", "index write inside retrace", int'(vretrace), 1);
            last_rise = rise_cnt;
            chk(int'(pal_idx) == mon_ptr / 3, "R2", "chunk index", int'(pal_idx), mon_ptr / 3);
            if (mon_cb != 0)
                chk(mon_cb == CB, "R3", "bytes in previous chunk", mon_cb, CB);
            mon_cb = 0;
            if (pal_idx == '0) up_cnt++;
        end
        if (rst_n && pal_dat_we) begin
            int e;
            dat_total++;
            e = model(int'(orig[mon_ptr]), int'(vtgt[mon_ptr % 3]), vstep, up_cnt);
            chk(vretrace == 1'b1, "R4", "data write inside retrace", int'(vretrace), 1);
            if (vstep != 1)
                chk(int'(pal_dat) == e, "R7", "byte after k uploads", int'(pal_dat), e);
            else if (vtgt[mon_ptr % 3] > orig[mon_ptr])
                chk(int'(pal_dat) == e, "R6", "rising component", int'(pal_dat), e);
            else
                chk(int'(pal_dat) == e, "R5", "falling component", int'(pal_dat), e);
            mon_ptr = (mon_ptr + 1) % NB;
            mon_cb++;
        end
    end

    task automatic load_table(input int base, input int mult);
        for (int j = 0; j < NB; j++) begin
            orig[j] = 8'((base + mult * j) & 255);
            @(negedge clk);
            load_we   = 1'b1;
            load_addr = AW'(j);
            load_data = orig[j];
        end
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic arm_and_start(input int s, input int r, input int g, input int b);
        wait (vretrace == 1'b1);
        repeat (3) @(negedge clk);
        vstep = s;
        vtgt[0] = 8'(r); vtgt[1] = 8'(g); vtgt[2] = 8'(b);
        step = 8'(s); tgt_red = 8'(r); tgt_grn = 8'(g); tgt_blu = 8'(b);
        up_cnt = 0; mon_ptr = 0; mon_cb = 0; last_rise = rise_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && done == 1'b0, "R10", "busy set, done cleared after start",
            int'({busy, done}), 2);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pal_idx_we && !pal_dat_we, "R1", "outputs in reset",
            int'({busy, done, pal_idx_we, pal_dat_we}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !pal_idx_we && !pal_dat_we, "R1", "outputs after reset",
            int'({busy, done, pal_idx_we, pal_dat_we}), 0);

        for (int v = 0; v < NVEC; v++) begin
            int s, tr, tg, tb, expu, waitc;
            s  = int'(VEC[v][47:40]);
            tr = int'(VEC[v][39:32]);
            tg = int'(VEC[v][31:24]);
            tb = int'(VEC[v][23:16]);
            load_table(int'(VEC[v][15:8]), int'(VEC[v][7:0]));
            expu = 0;
            if (s != 0) begin
                for (int j = 0; j < NB; j++) begin
                    int t, d, n;
                    t = (j % 3 == 0) ? tr : ((j % 3 == 1) ? tg : tb);
                    d = (t > int'(orig[j])) ? t - int'(orig[j]) : int'(orig[j]) - t;
                    n = (d + s - 1) / s;
                    if (n > expu) expu = n;
                end
            end
            arm_and_start(s, tr, tg, tb);
            waitc = 0;
            while (!done && waitc < 40000) begin
                @(negedge clk);
                waitc++;
            end
            chk(done && !busy, "R8", "done and idle at convergence", int'({done, busy}), 2);
            chk(up_cnt == expu, "R8", "uploads until no change", up_cnt, expu);
            if (expu > 0)
                chk(mon_cb == CB, "R3", "bytes in last chunk", mon_cb, CB);
            repeat (20) @(negedge clk);
            chk(done == 1'b1, "R10", "done held while idle", int'(done), 1);
        end

        // abort in the last byte of the first chunk
        begin
            int idx_before, dat_before, waitc;
            load_table(100, 0);
            arm_and_start(1, 0, 0, 0);
            waitc = 0;
            while (!(pal_dat_we && mon_cb == CB - 1) && waitc < 2000) begin
                @(negedge clk);
                waitc++;
            end
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
            waitc = 0;
            while (busy && waitc < 2000) begin
                @(negedge clk);
                waitc++;
            end
            chk(mon_cb == CB, "R9", "chunk completed under abort", mon_cb, CB);
            chk(!busy && !done, "R9", "idle without done", int'({busy, done}), 0);
            idx_before = idx_total;
            dat_before = dat_total;
            repeat (300) @(negedge clk);
            chk(idx_total == idx_before, "R9", "no index writes after abort", idx_total, idx_before);
            chk(dat_total == dat_before, "R9", "no data writes after abort", dat_total, dat_before);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule